// File: doc/BRIEF.md
# Dual-Queue Conversion Sequencer

This block walks a shared table of conversion command entries and turns them into conversion requests for an external analog-to-digital converter. Each table entry holds a channel number and a pause bit. A movable boundary index splits the table. The first queue always begins at entry 0 and runs up to the boundary. The second queue begins at the boundary, and a 5-bit mode code sets how it is triggered and whether it rescans. The block reports completion, pause and trigger-overrun status for each queue on plain flag outputs. Software clears these flags with one clear pulse per queue.

Conversion requests leave on a valid/ready channel, and the converter then answers with a one-cycle done pulse. Back-pressure works as follows. Once `req_valid` rises, it stays high and `req_chan` stays constant until a cycle in which `req_ready` is high. Only one conversion is ever in flight, so no new request appears until `conv_done` has been seen. The boundary is compared with the table index only when an entry is fetched. A boundary rewritten during a run therefore takes effect at the next fetch that reaches it.

Top module: `adcq_seq_top`

## Requirements
- R1: Queue 1 starts at entry 0 and ends, setting `q1_done_flag`, when it fetches the entry whose index equals `boundary`. That entry is not converted, so a boundary of 0 gives a completed queue 1 with no conversion.
- R2: A boundary rewritten during a queue 1 run to an index ahead of the current entry ends the run when that index is fetched.
- R3: A boundary rewritten to the index being converted, or to an index behind it, lets the current conversion finish. The run then continues to the end of the table, and the next queue 1 run stops at the new index.
- R4: A fetched channel value of 63 ends either queue without a conversion. A queue also ends after converting table entry DEPTH-1.
- R5: Queue 2 starts at `boundary`. The continuous modes are: code 10010, triggered by `q2_sw_trig`; code 10011, triggered by a rising edge of `q2_ext_in`; code 10100, triggered by a falling edge of `q2_ext_in`. In these modes every later trigger restarts the scan from the first entry.
- R6: Codes 10101 to 11110 trigger queue 2 from a periodic timer every 2^(code-14) clock cycles, and the scan is continuous.
- R7: Codes 01011 to 01110 trigger queue 2 from a timer every 2^(code+3) clock cycles. After one scan the queue stays idle until the mode code is rewritten.
- R8: Codes 10000, 10001 and 11111 start no conversion, and neither do the other unlisted codes.
- R9: `req_valid` is held with `req_chan` stable until `req_ready`. The next request comes only after `conv_done`.
- R10: An entry with the pause bit (table bit 6; bits 5:0 are the channel) sets the queue's pause flag after its conversion. The queue then stops, and its next trigger resumes at the following entry.
- R11: A trigger that arrives while its queue is running or suspended sets that queue's overrun flag. Such a trigger does not restart the queue.
- R12: Queue 1 has priority. A queue 1 trigger during a queue 2 scan suspends queue 2 after its current conversion. Queue 2 resumes at its next entry once queue 1 completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timer step |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 6 | Table write index |
| tbl_wdata | input | 7 | Entry: bit 6 pause, bits 5:0 channel |
| boundary | input | 6 | Queue split index |
| q2_mode | input | 5 | Queue 2 trigger/scan code |
| q1_trig | input | 1 | Queue 1 trigger pulse |
| q2_sw_trig | input | 1 | Queue 2 software trigger pulse |
| q2_ext_in | input | 1 | Queue 2 external trigger level |
| q1_clr | input | 1 | Clears queue 1 flags |
| q2_clr | input | 1 | Clears queue 2 flags |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Converter accepts request |
| req_chan | output | 6 | Channel to convert |
| conv_done | input | 1 | Conversion finished pulse |
| q1_done_flag | output | 1 | Queue 1 completed |
| q1_pause_flag | output | 1 | Queue 1 paused |
| q1_overrun | output | 1 | Queue 1 trigger overrun |
| q2_done_flag | output | 1 | Queue 2 completed |
| q2_pause_flag | output | 1 | Queue 2 paused |
| q2_overrun | output | 1 | Queue 2 trigger overrun |

## Verification
The assertions assume that `conv_done` pulses for exactly one cycle, and only for a request that has already been accepted. They also assume that triggers and clears are single-cycle pulses and that `q2_mode` is steady while a timer trigger fires. The bench converter model answers every accepted request exactly once, after a fixed latency. The bench changes the boundary and the mode only on clock half-cycles away from the active edge, and it raises each trigger for a single cycle.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

  typedef enum logic [2:0] {SRC_NONE, SRC_SW, SRC_RISE, SRC_FALL, SRC_TIMER} q2_src_e;

  typedef struct packed {
    q2_src_e    src;
    logic       cont;
    logic [4:0] expo;
  } q2_cfg_t;

  typedef enum logic [1:0] {E_IDLE, E_FETCH, E_REQ, E_WAIT} eng_st_e;

  localparam logic [4:0] MODE_SW   = 5'b10010;
  localparam logic [4:0] MODE_RISE = 5'b10011;
  localparam logic [4:0] MODE_FALL = 5'b10100;
  localparam logic [4:0] PER_LO    = 5'b10101;
  localparam logic [4:0] PER_HI    = 5'b11110;
  localparam logic [4:0] INT_LO    = 5'b01011;
  localparam logic [4:0] INT_HI    = 5'b01110;

  // Mode code to trigger source, rescan choice and timer exponent.
  function automatic q2_cfg_t q2_decode(input logic [4:0] m);
    q2_cfg_t c;
    c.src  = SRC_NONE;
    c.cont = 1'b0;
    c.expo = '0;
    if (m == MODE_SW) begin
      c.src = SRC_SW;   c.cont = 1'b1;
    end else if (m == MODE_RISE) begin
      c.src = SRC_RISE; c.cont = 1'b1;
    end else if (m == MODE_FALL) begin
      c.src = SRC_FALL; c.cont = 1'b1;
    end else if (m >= PER_LO && m <= PER_HI) begin
      c.src = SRC_TIMER; c.cont = 1'b1; c.expo = m - 5'd14;
    end else if (m >= INT_LO && m <= INT_HI) begin
      c.src = SRC_TIMER; c.expo = m + 5'd3;
    end
    return c;
  endfunction

endpackage

// File: rtl/adcq_cmd_table.sv
module adcq_cmd_table #(
  parameter int DEPTH = 64,
  parameter int ENT_W = 7,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  logic [ENT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/adcq_q2_trigger.sv
module adcq_q2_trigger import adcq_pkg::*; #(
  parameter int TMR_W = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] mode,
  input  logic       sw_trig,
  input  logic       ext_in,
  output logic       trig,
  output logic       cont,
  output logic       mode_chg
);
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] tick_mask;
  logic             ext_q;
  logic [4:0]       mode_q;
  logic             tick;
  q2_cfg_t          cfg;

  assign cfg       = q2_decode(mode);
  assign tick_mask = (TMR_W'(1) << cfg.expo) - TMR_W'(1);
  assign tick      = (tmr_q & tick_mask) == tick_mask;
  assign cont      = cfg.cont;
  assign mode_chg  = mode != mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      ext_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      tmr_q  <= tmr_q + TMR_W'(1);
      ext_q  <= ext_in;
      mode_q <= mode;
    end
  end

  always_comb begin
    case (cfg.src)
      SRC_SW:    trig = sw_trig;
      SRC_RISE:  trig = ext_in & ~ext_q;
      SRC_FALL:  trig = ~ext_in & ext_q;
      SRC_TIMER: trig = tick;
      default:   trig = 1'b0;
    endcase
  end

  // R6: timer triggers are at least two cycles apart while the mode holds
  a_r6_timer_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.src == SRC_TIMER && trig) |=> (!trig || !$stable(mode)));

endmodule

// File: rtl/adcq_engine.sv
module adcq_engine import adcq_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int CH_W  = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ENT_W = CH_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] boundary,
  input  logic             q1_trig,
  input  logic             q2_trig,
  input  logic             q2_cont,
  input  logic             q2_mode_chg,
  input  logic             q1_clr,
  input  logic             q2_clr,
  output logic [IDX_W-1:0] ent_idx,
  input  logic [ENT_W-1:0] ent_data,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [CH_W-1:0]  req_chan,
  input  logic             conv_done,
  output logic             cf1, pf1, tor1,
  output logic             cf2, pf2, tor2
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CH_W-1:0]  END_CH   = '1;

  eng_st_e          st;
  logic             serve_q2;
  logic             q1_run, q1_pau, q2_run, q2_pau, q2_armed;
  logic [IDX_W-1:0] q1_ptr, q2_ptr;
  logic [ENT_W-1:0] cur_ent;
  logic             q2_fire, hit_end, at_last;

  assign ent_idx   = serve_q2 ? q2_ptr : q1_ptr;
  assign q2_fire   = q2_trig & (q2_cont | q2_armed);
  assign hit_end   = (ent_data[CH_W-1:0] == END_CH) || (!serve_q2 && ent_idx == boundary);
  assign at_last   = ent_idx == LAST_IDX;
  assign req_valid = st == E_REQ;
  assign req_chan  = cur_ent[CH_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= E_IDLE; serve_q2 <= 1'b0; cur_ent <= '0;
      q1_run <= 1'b0; q1_pau <= 1'b0; q1_ptr <= '0;
      q2_run <= 1'b0; q2_pau <= 1'b0; q2_ptr <= '0; q2_armed <= 1'b1;
      cf1 <= 1'b0; pf1 <= 1'b0; tor1 <= 1'b0;
      cf2 <= 1'b0; pf2 <= 1'b0; tor2 <= 1'b0;
    end else begin
      if (q1_clr) begin cf1 <= 1'b0; pf1 <= 1'b0; tor1 <= 1'b0; end
      if (q2_clr) begin cf2 <= 1'b0; pf2 <= 1'b0; tor2 <= 1'b0; end
      if (q2_mode_chg) q2_armed <= 1'b1;

      if (q1_trig) begin
        if (q1_run)      tor1 <= 1'b1;
        else if (q1_pau) begin q1_pau <= 1'b0; q1_run <= 1'b1; end
        else             begin q1_ptr <= '0;   q1_run <= 1'b1; end
      end
      if (q2_fire) begin
        if (q2_run)      tor2 <= 1'b1;
        else if (q2_pau) begin q2_pau <= 1'b0; q2_run <= 1'b1; end
        else             begin q2_ptr <= boundary; q2_run <= 1'b1; end
      end

      case (st)
        E_IDLE: begin
          if (q1_run)      begin serve_q2 <= 1'b0; st <= E_FETCH; end
          else if (q2_run) begin serve_q2 <= 1'b1; st <= E_FETCH; end
        end
        E_FETCH: begin
          if (hit_end) begin
            st <= E_IDLE;
            if (serve_q2) begin
              q2_run <= 1'b0; cf2 <= 1'b1;
              if (!q2_cont) q2_armed <= 1'b0;
            end else begin
              q1_run <= 1'b0; cf1 <= 1'b1;
            end
          end else begin
            cur_ent <= ent_data;
            st      <= E_REQ;
          end
        end
        E_REQ: if (req_ready) st <= E_WAIT;
        E_WAIT: begin
          if (conv_done) begin
            st <= E_IDLE;
            if (serve_q2) begin
              if (cur_ent[CH_W]) pf2 <= 1'b1;
              if (at_last) begin
                q2_run <= 1'b0; cf2 <= 1'b1;
                if (!q2_cont) q2_armed <= 1'b0;
              end else begin
                q2_ptr <= q2_ptr + IDX_W'(1);
                if (cur_ent[CH_W]) begin q2_run <= 1'b0; q2_pau <= 1'b1; end
              end
            end else begin
              if (cur_ent[CH_W]) pf1 <= 1'b1;
              if (at_last) begin
                q1_run <= 1'b0; cf1 <= 1'b1;
              end else begin
                q1_ptr <= q1_ptr + IDX_W'(1);
                if (cur_ent[CH_W]) begin q1_run <= 1'b0; q1_pau <= 1'b1; end
              end
            end
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // R9: a request under back-pressure holds its channel
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_chan)));

  // R10: raising a pause flag leaves the queue stopped, not running
  a_r10_pause_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf1) |-> (!q1_run && q1_pau));

  // R11: overrun flags only rise for a queue already busy
  a_r11_tor1_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tor1) |-> $past(q1_run));
  a_r11_tor2_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tor2) |-> $past(q2_run));

  // R12: queue 2 is only fetched if queue 1 was not pending when chosen
  a_r12_q1_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_FETCH && serve_q2 && $past(st) == E_IDLE) |-> $past(!q1_run));

  // R7: a spent single scan stays idle while the mode holds
  a_r7_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!q2_armed && !q2_cont && !q2_run && !q2_pau && !q2_mode_chg) |=> !q2_run);

endmodule

// File: rtl/adcq_seq_top.sv
module adcq_seq_top import adcq_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int CH_W  = 6,
  parameter int TMR_W = 17,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ENT_W = CH_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [ENT_W-1:0] tbl_wdata,
  input  logic [IDX_W-1:0] boundary,
  input  logic [4:0]       q2_mode,
  input  logic             q1_trig,
  input  logic             q2_sw_trig,
  input  logic             q2_ext_in,
  input  logic             q1_clr,
  input  logic             q2_clr,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [CH_W-1:0]  req_chan,
  input  logic             conv_done,
  output logic             q1_done_flag,
  output logic             q1_pause_flag,
  output logic             q1_overrun,
  output logic             q2_done_flag,
  output logic             q2_pause_flag,
  output logic             q2_overrun
);
  logic [IDX_W-1:0] rd_idx;
  logic [ENT_W-1:0] rd_ent;
  logic             q2_trig, q2_cont, q2_mode_chg;

  adcq_cmd_table #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr(rd_idx), .rdata(rd_ent));

  adcq_q2_trigger #(.TMR_W(TMR_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .mode(q2_mode), .sw_trig(q2_sw_trig), .ext_in(q2_ext_in),
    .trig(q2_trig), .cont(q2_cont), .mode_chg(q2_mode_chg));

  adcq_engine #(.DEPTH(DEPTH), .CH_W(CH_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .q1_trig(q1_trig), .q2_trig(q2_trig), .q2_cont(q2_cont), .q2_mode_chg(q2_mode_chg),
    .q1_clr(q1_clr), .q2_clr(q2_clr), .ent_idx(rd_idx), .ent_data(rd_ent),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan), .conv_done(conv_done),
    .cf1(q1_done_flag), .pf1(q1_pause_flag), .tor1(q1_overrun),
    .cf2(q2_done_flag), .pf2(q2_pause_flag), .tor2(q2_overrun));
endmodule

// File: tb/tb_adcq_seq_top.sv
module tb_adcq_seq_top;
  localparam int LAT = 4;
  localparam int LOGN = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [6:0] tbl_wdata = '0;
  logic [5:0] boundary = '0;
  logic [4:0] q2_mode = 5'b10000;
  logic q1_trig = 1'b0, q2_sw_trig = 1'b0, q2_ext_in = 1'b0;
  logic q1_clr = 1'b0, q2_clr = 1'b0;
  logic req_valid, req_ready, conv_done;
  logic [5:0] req_chan;
  logic q1_done_flag, q1_pause_flag, q1_overrun, q2_done_flag, q2_pause_flag, q2_overrun;
  logic stall = 1'b0;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int wr_n = 0;
  int busy_cnt = 0;
  int log_ch [LOGN];
  int log_ts [LOGN];

  always #10 clk = ~clk;

  adcq_seq_top dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .boundary(boundary), .q2_mode(q2_mode), .q1_trig(q1_trig), .q2_sw_trig(q2_sw_trig),
    .q2_ext_in(q2_ext_in), .q1_clr(q1_clr), .q2_clr(q2_clr), .req_valid(req_valid),
    .req_ready(req_ready), .req_chan(req_chan), .conv_done(conv_done),
    .q1_done_flag(q1_done_flag), .q1_pause_flag(q1_pause_flag), .q1_overrun(q1_overrun),
    .q2_done_flag(q2_done_flag), .q2_pause_flag(q2_pause_flag), .q2_overrun(q2_overrun));

  assign req_ready = !stall;

  // Behavioural converter: logs each accepted channel, answers LAT cycles later.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    conv_done <= 1'b0;
    if (!rst_n) begin
      busy_cnt <= 0;
    end else begin
      if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1) conv_done <= 1'b1;
      end
      if (req_valid && req_ready) begin
        log_ch[wr_n % LOGN] <= int'(req_chan);
        log_ts[wr_n % LOGN] <= cyc;
        wr_n <= wr_n + 1;
        busy_cnt <= LAT;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ent(input int idx, input logic pau, input int ch);
    tbl_we = 1'b1; tbl_addr = 6'(idx); tbl_wdata = {pau, 6'(ch)};
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic pulse_q1();
    q1_trig = 1'b1; @(negedge clk); q1_trig = 1'b0;
  endtask

  task automatic pulse_sw();
    q2_sw_trig = 1'b1; @(negedge clk); q2_sw_trig = 1'b0;
  endtask

  task automatic clr_all();
    q1_clr = 1'b1; q2_clr = 1'b1; @(negedge clk); q1_clr = 1'b0; q2_clr = 1'b0;
  endtask

  task automatic wait_cf1();
    do @(negedge clk); while (!q1_done_flag);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_cf2();
    do @(negedge clk); while (!q2_done_flag);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_n(input int target);
    while (wr_n < target) @(negedge clk);
  endtask

  // Vectors: {boundary[12:7], expected queue 1 conversion count[6:0]}
  localparam logic [12:0] Q1_VEC [5] = '{
    {6'd0, 7'd0}, {6'd1, 7'd1}, {6'd5, 7'd5}, {6'd12, 7'd12}, {6'd40, 7'd40}};

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int base, n, bad, f, e, c0, runs, t0, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R9 reset valid", int'(req_valid), 0);
    chk("R11 reset flags", int'({q1_done_flag, q1_pause_flag, q1_overrun,
                                 q2_done_flag, q2_pause_flag, q2_overrun}), 0);
    for (int i = 0; i < 64; i++) wr_ent(i, 1'b0, i);

    // R1: vector walk
    for (int v = 0; v < 5; v++) begin
      boundary = Q1_VEC[v][12:7];
      base = wr_n;
      pulse_q1();
      wait_cf1();
      chk("R1 count", wr_n - base, int'(Q1_VEC[v][6:0]));
      if (Q1_VEC[v][6:0] != 0)
        chk("R1 last chan", log_ch[base + int'(Q1_VEC[v][6:0]) - 1], int'(Q1_VEC[v][6:0]) - 1);
      clr_all();
    end

    // R2: boundary moved ahead mid-run
    boundary = 6'd40; base = wr_n;
    pulse_q1(); wait_n(base + 3); boundary = 6'd10;
    wait_cf1();
    chk("R2 ahead count", wr_n - base, 10);
    clr_all();

    // R3: boundary moved behind mid-run
    boundary = 6'd40; base = wr_n;
    pulse_q1(); wait_n(base + 6); boundary = 6'd3;
    wait_cf1();
    chk("R3 behind runs to end", wr_n - base, 63);
    clr_all(); base = wr_n;
    pulse_q1(); wait_cf1();
    chk("R3 behind next pass", wr_n - base, 3);
    clr_all();

    // R3: boundary equal to the entry in conversion
    boundary = 6'd40; base = wr_n;
    pulse_q1(); wait_n(base + 6); boundary = 6'd5;
    wait_cf1();
    chk("R3 equal count", wr_n - base, 63);
    chk("R3 equal entry kept", log_ch[base + 5], 5);
    clr_all(); base = wr_n;
    pulse_q1(); wait_cf1();
    chk("R3 equal next pass", wr_n - base, 5);
    clr_all();

    // R4: end marker
    wr_ent(7, 1'b0, 63);
    boundary = 6'd40; base = wr_n;
    pulse_q1(); wait_cf1();
    chk("R4 marker count", wr_n - base, 7);
    wr_ent(7, 1'b0, 7);
    clr_all();

    // R10: pause bit
    wr_ent(2, 1'b1, 2);
    boundary = 6'd6; base = wr_n;
    pulse_q1();
    do @(negedge clk); while (!q1_pause_flag);
    repeat (4) @(negedge clk);
    chk("R10 paused count", wr_n - base, 3);
    chk("R10 not complete", int'(q1_done_flag), 0);
    pulse_q1(); wait_cf1();
    chk("R10 resumed count", wr_n - base, 6);
    chk("R10 resume entry", log_ch[base + 3], 3);
    wr_ent(2, 1'b0, 2);
    clr_all();

    // R11: queue 1 overrun
    boundary = 6'd40; base = wr_n;
    pulse_q1(); wait_n(base + 2); pulse_q1();
    wait_cf1();
    chk("R11 tor1", int'(q1_overrun), 1);
    chk("R11 no restart", wr_n - base, 40);
    clr_all();

    // R9: back-pressure
    stall = 1'b1; boundary = 6'd4; base = wr_n; bad = 0;
    pulse_q1();
    while (!req_valid) @(negedge clk);
    c0 = int'(req_chan);
    repeat (3) begin
      @(negedge clk);
      if (!req_valid || int'(req_chan) != c0) bad++;
    end
    stall = 1'b0;
    wait_cf1();
    chk("R9 hold under stall", bad, 0);
    chk("R9 count", wr_n - base, 4);
    clr_all();

    // Queue 2 region 50..55, marker at 56
    wr_ent(56, 1'b0, 63);
    boundary = 6'd50;

    // R8: reserved codes
    base = wr_n;
    q2_mode = 5'b10000; @(negedge clk);
    pulse_sw(); q2_ext_in = 1'b1; repeat (5) @(negedge clk); q2_ext_in = 1'b0;
    q2_mode = 5'b11111; repeat (300) @(negedge clk);
    pulse_sw(); q2_ext_in = 1'b1; repeat (5) @(negedge clk); q2_ext_in = 1'b0;
    q2_mode = 5'b10001; repeat (300) @(negedge clk);
    chk("R8 reserved idle", wr_n - base, 0);

    // R5: software continuous
    q2_mode = 5'b10010; @(negedge clk);
    base = wr_n;
    pulse_sw(); wait_cf2();
    chk("R5 sw count", wr_n - base, 6);
    chk("R5 sw first", log_ch[base], 50);
    clr_all(); base = wr_n;
    pulse_sw(); wait_cf2();
    chk("R5 sw rescan", wr_n - base, 6);
    chk("R5 sw rescan first", log_ch[base], 50);
    clr_all();

    // R5: rising edge
    q2_mode = 5'b10011; @(negedge clk);
    base = wr_n;
    q2_ext_in = 1'b1; wait_cf2();
    chk("R5 rise count", wr_n - base, 6);
    clr_all(); base = wr_n;
    q2_ext_in = 1'b0; repeat (100) @(negedge clk);
    chk("R5 rise ignores fall", wr_n - base, 0);

    // R5: falling edge
    q2_mode = 5'b10100; @(negedge clk);
    base = wr_n;
    q2_ext_in = 1'b1; repeat (100) @(negedge clk);
    chk("R5 fall ignores rise", wr_n - base, 0);
    q2_ext_in = 1'b0; wait_cf2();
    chk("R5 fall count", wr_n - base, 6);
    clr_all();

    // R6: periodic 10101 -> 128-cycle period
    base = wr_n;
    q2_mode = 5'b10101;
    repeat (600) @(negedge clk);
    q2_mode = 5'b10000;
    repeat (100) @(negedge clk);
    runs = 0; t0 = 0; t1 = 0; t2 = 0;
    for (int k = base; k < wr_n; k++) begin
      if (log_ch[k] == 50) begin
        if (runs == 0) t0 = log_ts[k];
        else if (runs == 1) t1 = log_ts[k];
        else if (runs == 2) t2 = log_ts[k];
        runs++;
      end
    end
    chk("R6 at least three runs", int'(runs >= 3), 1);
    chk("R6 period first", t1 - t0, 128);
    chk("R6 period second", t2 - t1, 128);
    clr_all();

    // R7: interval single scan 01011 -> one scan per mode write
    base = wr_n;
    q2_mode = 5'b01011;
    repeat (17000) @(negedge clk);
    chk("R7 one scan", wr_n - base, 6);
    chk("R7 done flag", int'(q2_done_flag), 1);
    repeat (17000) @(negedge clk);
    chk("R7 stays idle", wr_n - base, 6);
    q2_mode = 5'b10000; @(negedge clk);
    q2_mode = 5'b01011;
    repeat (17000) @(negedge clk);
    chk("R7 rearmed", wr_n - base, 12);
    q2_mode = 5'b10000; @(negedge clk);
    clr_all();

    // R12 and R11: priority and queue 2 overrun
    wr_ent(56, 1'b0, 56);
    boundary = 6'd20;
    q2_mode = 5'b10010; @(negedge clk);
    base = wr_n;
    pulse_sw(); wait_n(base + 3);
    pulse_q1(); pulse_sw();
    do @(negedge clk); while (!(q1_done_flag && q2_done_flag));
    repeat (4) @(negedge clk);
    n = wr_n - base;
    chk("R11 tor2", int'(q2_overrun), 1);
    chk("R12 total", n, 63);
    f = -1;
    for (int k = 0; k < n; k++) if (f < 0 && log_ch[base + k] == 0) f = k;
    chk("R12 q2 first", int'(f >= 3), 1);
    bad = 0;
    for (int k = 0; k < 20; k++) if (f < 0 || log_ch[base + f + k] != k) bad++;
    chk("R12 q1 contiguous", bad, 0);
    bad = 0; e = 20;
    for (int k = 0; k < n; k++) begin
      if (k < f || k >= f + 20) begin
        if (log_ch[base + k] != e) bad++;
        e++;
      end
    end
    chk("R12 q2 resumes in order", bad, 0);
    chk("R12 q2 entries", e, 63);
    clr_all();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule